// File: doc/BRIEF.md
# Two-Level Value Predictor

This block predicts the next data value that an operation will produce. It keeps a small table of first-level entries, each selected by an index that the caller assigns. Each entry stores four candidate data values. It also stores a history that records which of those four candidates turned out to be correct on each of the last six trainings. That history addresses a second-level pattern table, which is shared by all entries. Each pattern table word holds four saturating counters, one for each candidate slot. The predicted value is the candidate whose counter is highest, so a value is produced on every request.

There are two independent ports. The prediction port takes an index and returns the predicted value one cycle later. The training port takes an index and the value that was actually produced. When that value matches one of the entry's candidates, the counters favour that slot. When it matches none of them, the value replaces the weakest candidate. In both cases the chosen slot number is shifted into the entry's history. Both ports may be used in the same cycle.

Top module: `value_pred_2lvl`

## Requirements
- R1: After reset every candidate value, every history and every counter is zero. `pred_valid_o` is low, and a prediction for any index returns zero.
- R2: `pred_valid_o` is high exactly one cycle after `pred_valid_i` was high and low otherwise. The value it carries reflects the state before any training applied in the same cycle as the request.
- R3: The prediction for an index is the candidate in the slot whose counter is largest. The counters are read from the pattern-table word that the entry's history selects. On a tie the lowest-numbered slot wins.
- R4: When the trained value equals a stored candidate, the lowest such slot is the outcome. That slot's counter rises by 3 up to a ceiling of 12. Every other counter in the same word falls by 1 down to a floor of 0.
- R5: When the trained value equals no candidate, it overwrites the slot with the smallest counter, with the lowest slot winning a tie. That slot then counts as the outcome, and the counters are updated as in R4.
- R6: On every training, the entry's 12-bit history shifts left by two bits and the 2-bit outcome slot number enters at bits [1:0]. Outcomes older than six trainings are dropped.
- R7: The pattern table is shared by all entries. Entries with equal histories read and train the same counters.
- R8: A cycle with `train_valid_i` low changes no candidate, history or counter.
- R9: Training one index leaves the candidates and history of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid_i | input | 1 | Prediction request |
| pred_idx_i | input | 3 | Entry to predict |
| pred_valid_o | output | 1 | Prediction result valid, one cycle after request |
| pred_value_o | output | 32 | Predicted value |
| train_valid_i | input | 1 | Training request |
| train_idx_i | input | 3 | Entry to train |
| train_value_i | input | 32 | Value actually produced |

## Verification
The assertions assume that the inputs are known and stable at each rising edge, and that reset is held for at least one edge before use. They also assume that the entry count is a power of two, so that every index value addresses a real entry. The stimulus drives inputs only at falling edges and holds everything low during reset. It draws trained values from a small pool so that hits, misses, replacements and saturation all occur repeatedly. It also repeats short periodic value sequences on several entries, so that histories coincide and the shared counters are exercised.

// File: rtl/vp_pkg.sv
package vp_pkg;
    localparam int VP_NVAL     = 4;
    localparam int VP_HIST_LEN = 6;
    localparam int VP_CTR_W    = 4;
    localparam int VP_CTR_MAX  = 12;
    localparam int VP_CTR_INC  = 3;
    localparam int VP_CTR_DEC  = 1;
endpackage

// File: rtl/vp_slot_pick.sv
module vp_slot_pick #(
    parameter int NVAL     = 4,
    parameter int CW       = 4,
    parameter bit PICK_MAX = 1'b1
) (
    input  logic [NVAL-1:0][CW-1:0]   cnt_i,
    output logic [$clog2(NVAL)-1:0]   slot_o
);
    localparam int SW = $clog2(NVAL);

    logic [SW-1:0] best;

    generate
        if (PICK_MAX) begin : g_max
            always_comb begin
                best = '0;
                for (int i = 1; i < NVAL; i++) begin
                    if (cnt_i[i] > cnt_i[best]) best = SW'(i);
                end
            end
        end else begin : g_min
            always_comb begin
                best = '0;
                for (int i = 1; i < NVAL; i++) begin
                    if (cnt_i[i] < cnt_i[best]) best = SW'(i);
                end
            end
        end
    endgenerate

    assign slot_o = best;
endmodule

// File: rtl/vp_ctr_update.sv
module vp_ctr_update #(
    parameter int NVAL = 4,
    parameter int CW   = 4,
    parameter int CMAX = 12,
    parameter int INC  = 3,
    parameter int DEC  = 1
) (
    input  logic [NVAL-1:0][CW-1:0]  cnt_i,
    input  logic [$clog2(NVAL)-1:0]  win_i,
    output logic [NVAL-1:0][CW-1:0]  cnt_o
);
    localparam int SW = $clog2(NVAL);

    for (genvar g = 0; g < NVAL; g++) begin : g_ctr
        logic [CW:0]   up_sum;
        logic [CW-1:0] up_sat;
        logic [CW-1:0] dn_sat;
        assign up_sum   = {1'b0, cnt_i[g]} + (CW+1)'(INC);
        assign up_sat   = (up_sum > (CW+1)'(CMAX)) ? CW'(CMAX) : up_sum[CW-1:0];
        assign dn_sat   = (cnt_i[g] < CW'(DEC)) ? '0 : cnt_i[g] - CW'(DEC);
        assign cnt_o[g] = (win_i == SW'(g)) ? up_sat : dn_sat;
    end
endmodule

// File: rtl/vp_pattern_table.sv
module vp_pattern_table #(
    parameter int HW   = 12,
    parameter int NVAL = 4,
    parameter int CW   = 4,
    parameter int CMAX = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HW-1:0]            rd_a_addr_i,
    output logic [NVAL-1:0][CW-1:0]  rd_a_data_o,
    input  logic [HW-1:0]            rd_b_addr_i,
    output logic [NVAL-1:0][CW-1:0]  rd_b_data_o,
    input  logic                     we_i,
    input  logic [HW-1:0]            wr_addr_i,
    input  logic [NVAL-1:0][CW-1:0]  wr_data_i
);
    localparam int DEPTH = 1 << HW;

    logic [NVAL-1:0][CW-1:0] mem_q [DEPTH];

    assign rd_a_data_o = mem_q[rd_a_addr_i];
    assign rd_b_data_o = mem_q[rd_b_addr_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NVAL; g++) begin : g_chk
        AST_CTR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
            we_i |-> (wr_data_i[g] <= CW'(CMAX))); // R4
    end
endmodule

// File: rtl/value_pred_2lvl.sv
module value_pred_2lvl
    import vp_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int DW       = 32,
    parameter int NVAL     = VP_NVAL,
    parameter int HIST_LEN = VP_HIST_LEN,
    parameter int CW       = VP_CTR_W,
    parameter int CMAX     = VP_CTR_MAX,
    parameter int INC      = VP_CTR_INC,
    parameter int DEC      = VP_CTR_DEC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pred_valid_i,
    input  logic [$clog2(ENTRIES)-1:0]    pred_idx_i,
    output logic                          pred_valid_o,
    output logic [DW-1:0]                 pred_value_o,
    input  logic                          train_valid_i,
    input  logic [$clog2(ENTRIES)-1:0]    train_idx_i,
    input  logic [DW-1:0]                 train_value_i
);
    localparam int SW = $clog2(NVAL);
    localparam int HW = HIST_LEN * SW;

    typedef struct packed {
        logic [NVAL-1:0][DW-1:0] vals;
        logic [HW-1:0]           hist;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 pv;
        logic [DW-1:0]        pval;
    } state_t;

    state_t st_d, st_q;

    logic [HW-1:0]            p_hist, t_hist;
    logic [NVAL-1:0][CW-1:0]  p_cnt, t_cnt, t_cnt_new;
    logic [SW-1:0]            p_slot, victim, hit_slot, outcome;
    logic                     hit;
    entry_t                   t_ent;

    assign p_hist = st_q.ent[pred_idx_i].hist;
    assign t_ent  = st_q.ent[train_idx_i];
    assign t_hist = t_ent.hist;

    vp_pattern_table #(.HW(HW), .NVAL(NVAL), .CW(CW), .CMAX(CMAX)) u_pt (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a_addr_i (p_hist),
        .rd_a_data_o (p_cnt),
        .rd_b_addr_i (t_hist),
        .rd_b_data_o (t_cnt),
        .we_i        (train_valid_i),
        .wr_addr_i   (t_hist),
        .wr_data_i   (t_cnt_new)
    );

    vp_slot_pick #(.NVAL(NVAL), .CW(CW), .PICK_MAX(1'b1)) u_pick_pred (
        .cnt_i  (p_cnt),
        .slot_o (p_slot)
    );

    vp_slot_pick #(.NVAL(NVAL), .CW(CW), .PICK_MAX(1'b0)) u_pick_victim (
        .cnt_i  (t_cnt),
        .slot_o (victim)
    );

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = NVAL - 1; i >= 0; i--) begin
            if (t_ent.vals[i] == train_value_i) begin
                hit      = 1'b1;
                hit_slot = SW'(i);
            end
        end
    end

    assign outcome = hit ? hit_slot : victim;

    vp_ctr_update #(.NVAL(NVAL), .CW(CW), .CMAX(CMAX), .INC(INC), .DEC(DEC)) u_upd (
        .cnt_i (t_cnt),
        .win_i (outcome),
        .cnt_o (t_cnt_new)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pv = pred_valid_i;
        if (pred_valid_i) begin
            st_d.pval = st_q.ent[pred_idx_i].vals[p_slot];
        end
        if (train_valid_i) begin
            if (!hit) begin
                st_d.ent[train_idx_i].vals[outcome] = train_value_i;
            end
            st_d.ent[train_idx_i].hist = {t_hist[HW-SW-1:0], outcome};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid_o = st_q.pv;
    assign pred_value_o = st_q.pval;

    AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> pred_valid_o); // R2
    AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_i |=> !pred_valid_o); // R2
    AST_TRAIN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid_i |=> (st_q.ent[$past(train_idx_i)].vals[st_q.ent[$past(train_idx_i)].hist[SW-1:0]]
                           == $past(train_value_i))); // R5
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid_i |=> (st_q.ent[$past(train_idx_i)].hist[HW-1:SW]
                           == $past(st_q.ent[train_idx_i].hist[HW-SW-1:0]))); // R6
    AST_NO_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !train_valid_i |=> $stable(st_q.ent)); // R8
endmodule

// File: tb/tb_value_pred_2lvl.sv
module tb_value_pred_2lvl;
    localparam int ENT = 8;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid_i = 1'b0;
    logic [2:0]  pred_idx_i = '0;
    logic        pred_valid_o;
    logic [31:0] pred_value_o;
    logic        train_valid_i = 1'b0;
    logic [2:0]  train_idx_i = '0;
    logic [31:0] train_value_i = '0;

    always #5 clk = ~clk;

    value_pred_2lvl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pred_valid_i  (pred_valid_i),
        .pred_idx_i    (pred_idx_i),
        .pred_valid_o  (pred_valid_o),
        .pred_value_o  (pred_value_o),
        .train_valid_i (train_valid_i),
        .train_idx_i   (train_idx_i),
        .train_value_i (train_value_i)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    logic [31:0] mv [ENT][4];
    int          mh [ENT];
    int          mc [DEPTH][4];

    function automatic logic [31:0] model_pred(int e);
        int h = mh[e];
        int best = 0;
        for (int k = 1; k < 4; k++) if (mc[h][k] > mc[h][best]) best = k;
        return mv[e][best];
    endfunction

    function automatic void model_train(int e, logic [31:0] val);
        int h = mh[e];
        int o = -1;
        for (int k = 0; k < 4; k++) if (o < 0 && mv[e][k] == val) o = k;
        if (o < 0) begin
            o = 0;
            for (int k = 1; k < 4; k++) if (mc[h][k] < mc[h][o]) o = k;
            mv[e][o] = val;
        end
        for (int k = 0; k < 4; k++) begin
            if (k == o) mc[h][k] = (mc[h][k] + 3 > 12) ? 12 : mc[h][k] + 3;
            else        mc[h][k] = (mc[h][k] > 0) ? mc[h][k] - 1 : 0;
        end
        mh[e] = ((h << 2) | o) & 12'hFFF;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(input bit pv, input int pi, input bit tv, input int ti, input logic [31:0] tval);
        logic [31:0] exp;
        exp = model_pred(pi);
        pred_valid_i  = pv;
        pred_idx_i    = 3'(pi);
        train_valid_i = tv;
        train_idx_i   = 3'(ti);
        train_value_i = tval;
        if (tv) model_train(ti, tval);
        @(posedge clk);
        @(negedge clk);
        chk(pred_valid_o == pv, "valid (R2)", 32'(pred_valid_o), 32'(pv));
        if (pv) chk(pred_value_o == exp, "value", pred_value_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < ENT; e++) begin
            mh[e] = 0;
            for (int k = 0; k < 4; k++) mv[e][k] = '0;
        end
        for (int h = 0; h < DEPTH; h++)
            for (int k = 0; k < 4; k++) mc[h][k] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        chk(pred_valid_o == 1'b0, "valid after reset", 32'(pred_valid_o), 0);
        for (int e = 0; e < ENT; e++) begin
            step(1, e, 0, 0, 0);
            chk(pred_value_o == 32'h0, "zero value", pred_value_o, 0);
        end

        // R5: first miss fills slot 0 and is then predicted
        cur_req = "R5";
        step(0, 0, 1, 1, 32'h55);
        step(1, 1, 0, 0, 0);
        chk(pred_value_o == 32'h55, "replaced value", pred_value_o, 32'h55);

        // R4: repeated hits saturate the counter
        cur_req = "R4";
        for (int i = 0; i < 8; i++) step(1, 1, 1, 1, 32'h55);
        step(1, 1, 0, 0, 0);
        chk(pred_value_o == 32'h55, "saturated hit", pred_value_o, 32'h55);

        // R5: a stream of distinct values forces replacements
        cur_req = "R5";
        for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 32'h100 + 32'(i % 6));

        // R6: periodic pattern is learnt through the history
        cur_req = "R6";
        for (int i = 0; i < 60; i++) step(1, 2, 1, 2, 32'(10 * (1 + i % 3)));

        // R7: another entry with the same pattern shares counters
        cur_req = "R7";
        for (int i = 0; i < 30; i++) step(1, 3, 1, 3, 32'(10 * (1 + i % 3)));
        for (int e = 2; e < 4; e++) step(1, e, 0, 0, 0);

        // R8: predictions only, nothing trains
        cur_req = "R8";
        for (int r = 0; r < 2; r++)
            for (int e = 0; e < ENT; e++) step(1, e, 0, 0, 32'hDEAD);

        // R9: training one entry, observing another
        cur_req = "R9";
        for (int i = 0; i < 40; i++) step(1, 5, 1, 4, 32'(7 + i % 5));

        // R2: predict and train the same entry in one cycle
        cur_req = "R2";
        for (int i = 0; i < 40; i++) step(1, 6, 1, 6, 32'(20 + i % 4));
        for (int i = 0; i < 10; i++) step(i % 2, 6, 0, 0, 0);

        // R3: mixed traffic against the model
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, ENT - 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, ENT - 1)),
                 32'($urandom_range(1, 6)));
        end

        pred_valid_i  = 1'b0;
        train_valid_i = 1'b0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule